// File: doc/BRIEF.md
# Domain-Aware Memory Region Checker

This block decides, for every memory access, whether it may proceed or must end in a bus fault. Software fills a small table of region descriptors through a write port. Each descriptor holds an inclusive address window, an enable bit, and one 3-bit policy for each requester domain. The checker compares the access address with every window at once. When windows overlap, the lowest-numbered enabled one wins. The domain tag of the access selects one policy from the winning descriptor. That policy is then tested against the access's security state, privilege and direction.

Enforcement stays off until a global enable bit is set, and until then every access is let through. The decision is registered, so it appears the cycle after the request. It comes with a hit flag and the index of the region that decided it.

Top module: `region_guard`

## Requirements
- R1: A configuration write with `cfgWe` high uses `cfgSel` to pick the target. 0 loads the start bound of region `cfgIdx` from `cfgData`. 1 loads the end bound. 2 loads the attribute word: bit 0 is the region enable, and bits 3d+3..3d+1 hold the policy of domain d. 3 loads the global enable from `cfgData[0]` and ignores `cfgIdx`.
- R2: A region matches an access when its enable bit is set and start ≤ address ≤ end, with both bounds inclusive.
- R3: When several regions match, the one with the lowest index decides, and its index is reported on `rspRegion` with `rspHit` high. When no region matches, `rspHit` is 0 and `rspRegion` is 0.
- R4: The access's domain tag `reqDid` selects which policy of the deciding region is applied.
- R5: The policy threshold depends on the access level. Policy ≥ 1 admits secure privileged accesses. Policy ≥ 2 admits secure user accesses. Policy ≥ 3 admits non-secure privileged reads and policy ≥ 4 admits their writes. Policy ≥ 5 admits non-secure user reads and policy ≥ 6 admits their writes. Policy 0 admits nothing; 6 and 7 admit everything.
- R6: With enforcement on, a matched access whose policy admits it is granted, and otherwise it faults. On a valid response exactly one of `rspGrant` and `rspFault` is high.
- R7: While the global enable is clear, every access is granted, whatever the policy and whether or not a region matches.
- R8: With enforcement on, an access that matches no region faults.
- R9: The response is valid in the cycle after `reqValid` and only then. When `rspValid` is low, `rspGrant`, `rspFault` and `rspHit` are low.
- R10: Reset clears the global enable, disables every region and clears the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: start, end, attributes, global |
| cfgIdx | input | IDX_W (2) | Region index for configuration writes |
| cfgData | input | ADDR_W (32) | Configuration write data |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W (32) | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | 1 = secure access |
| reqPriv | input | 1 | 1 = privileged access |
| reqDid | input | DID_W (2) | Domain tag of the access |
| rspValid | output | 1 | Decision valid |
| rspGrant | output | 1 | Access allowed |
| rspFault | output | 1 | Access refused (bus fault) |
| rspHit | output | 1 | A region matched |
| rspRegion | output | IDX_W (2) | Index of the deciding region |

## Verification
Each decision and its hit and region fields are due exactly one rising edge after the request is driven. Requests are driven on a falling edge, and all five outputs are sampled 1 ns after the following rising edge. A configuration write is applied one edge before the next request, so the request sees the new descriptor. The quiet cycle after a request is sampled the same way, to show that the response does not linger.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_END    = 2'd1,
    SEL_ATTR   = 2'd2,
    SEL_GLOBAL = 2'd3
  } cfgSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic wrStart;
    logic wrEnd;
    logic wrAttr;
  } dpStrobe_t;

  localparam int POLICY_W = 3;

  // minimum policy value that admits an access of the given kind
  function automatic logic policyAllows(input logic [POLICY_W-1:0] pol,
                                        input logic secure,
                                        input logic priv,
                                        input logic write);
    logic [POLICY_W-1:0] need;
    case ({secure, priv})
      2'b11:   need = 3'd1;
      2'b10:   need = 3'd2;
      2'b01:   need = write ? 3'd4 : 3'd3;
      default: need = write ? 3'd6 : 3'd5;
    endcase
    return pol >= need;
  endfunction

endpackage

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic [1:0] cfgSel,
  input  logic      cfgEnBit,
  input  logic      reqValid,
  output dpStrobe_t strobe,
  output logic      enforce
);

  logic globalWr;

  assign globalWr = cfgWe && (cfgSel == SEL_GLOBAL);

  always_comb begin
    strobe.capture = reqValid;
    strobe.wrStart = cfgWe && (cfgSel == SEL_START);
    strobe.wrEnd   = cfgWe && (cfgSel == SEL_END);
    strobe.wrAttr  = cfgWe && (cfgSel == SEL_ATTR);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         enforce <= 1'b0;
    else if (globalWr) enforce <= cfgEnBit;
  end

  // R1
  global_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalWr |=> (enforce == $past(cfgEnBit)));

  // R1
  global_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalWr |=> $stable(enforce));

endmodule

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_DOM     = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int DID_W      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int POLS_W     = NUM_DOM * POLICY_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              enforce,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic              reqPriv,
  input  logic [DID_W-1:0]  reqDid,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspRegion
);

  logic [ADDR_W-1:0] startQ [NUM_REGIONS];
  logic [ADDR_W-1:0] endQ   [NUM_REGIONS];
  logic [POLS_W-1:0] polQ   [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] validQ;
  logic [NUM_REGIONS-1:0] hitVec;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic sel;
    assign sel = (cfgIdx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startQ[r] <= '0;
        endQ[r]   <= '0;
        polQ[r]   <= '0;
        validQ[r] <= 1'b0;
      end else begin
        if (strobe.wrStart && sel) startQ[r] <= cfgData;
        if (strobe.wrEnd && sel)   endQ[r]   <= cfgData;
        if (strobe.wrAttr && sel) begin
          validQ[r] <= cfgData[0];
          polQ[r]   <= cfgData[1 +: POLS_W];
        end
      end
    end

    assign hitVec[r] = validQ[r] && (reqAddr >= startQ[r]) && (reqAddr <= endQ[r]);
  end

  // lowest index wins
  logic [IDX_W-1:0] selIdx;
  logic             anyHit;
  always_comb begin
    selIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  logic [POLS_W-1:0]   selPols;
  logic [POLICY_W-1:0] selPol;
  logic                permitted;
  logic                decideGrant;

  assign selPols     = polQ[selIdx];
  assign selPol      = selPols[int'(reqDid) * POLICY_W +: POLICY_W];
  assign permitted   = policyAllows(selPol, reqSecure, reqPriv, reqWrite);
  assign decideGrant = !enforce || (anyHit && permitted);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspGrant  <= 1'b0;
      rspFault  <= 1'b0;
      rspHit    <= 1'b0;
      rspRegion <= '0;
    end else begin
      rspValid  <= strobe.capture;
      rspGrant  <= strobe.capture && decideGrant;
      rspFault  <= strobe.capture && !decideGrant;
      rspHit    <= strobe.capture && anyHit;
      rspRegion <= strobe.capture ? selIdx : '0;
    end
  end

  logic [NUM_REGIONS-1:0] lowMask;
  assign lowMask = (NUM_REGIONS'(1) << selIdx) - NUM_REGIONS'(1);

  // R3
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (hitVec[selIdx] && ($countones(hitVec & lowMask) == 0)));

  // R9
  rsp_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (!rspValid && !rspGrant && !rspFault && !rspHit));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspGrant != rspFault));

  // R7
  open_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !enforce) |=> rspGrant);

  // R8
  miss_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && enforce && !anyHit) |=> rspFault);

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_DOM     = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int DID_W      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic              reqPriv,
  input  logic [DID_W-1:0]  reqDid,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspRegion
);

  dpStrobe_t strobe;
  logic      enforce;

  region_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgEnBit (cfgData[0]),
    .reqValid (reqValid),
    .strobe   (strobe),
    .enforce  (enforce)
  );

  region_guard_dp #(
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_DOM     (NUM_DOM),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .enforce   (enforce),
    .cfgIdx    (cfgIdx),
    .cfgData   (cfgData),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqSecure (reqSecure),
    .reqPriv   (reqPriv),
    .reqDid    (reqDid),
    .rspValid  (rspValid),
    .rspGrant  (rspGrant),
    .rspFault  (rspFault),
    .rspHit    (rspHit),
    .rspRegion (rspRegion)
  );

endmodule

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqSecure = 1'b0;
  logic        reqPriv = 1'b0;
  logic [1:0]  reqDid = '0;
  logic        rspValid, rspGrant, rspFault, rspHit;
  logic [1:0]  rspRegion;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqSecure(reqSecure), .reqPriv(reqPriv), .reqDid(reqDid),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspFault(rspFault),
    .rspHit(rspHit), .rspRegion(rspRegion)
  );

  // model of the programmed state
  logic [31:0] mStart [4];
  logic [31:0] mEnd   [4];
  logic        mValid [4];
  logic [11:0] mPol   [4];
  logic        mEnf;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [1:0] idx,
                          input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = idx; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: mStart[idx] = data;
      2'd1: mEnd[idx] = data;
      2'd2: begin mValid[idx] = data[0]; mPol[idx] = data[12:1]; end
      default: mEnf = data[0];
    endcase
  endtask

  // packs {valid, per-domain policies} into an attribute word
  function automatic logic [31:0] attrWord(input bit en, input int p0, input int p1,
                                           input int p2, input int p3);
    return 32'(en) | (32'(p0 & 7) << 1) | (32'(p1 & 7) << 4) |
           (32'(p2 & 7) << 7) | (32'(p3 & 7) << 10);
  endfunction

  task automatic access(input logic [31:0] addr, input int did, input int kind,
                        input string req);
    bit expHit, expGrant;
    int expIdx, pol, need;
    bit sec, prv, wr;
    sec = kind[2]; prv = kind[1]; wr = kind[0];
    expHit = 1'b0; expIdx = 0;
    for (int i = 3; i >= 0; i--) begin
      if (mValid[i] && addr >= mStart[i] && addr <= mEnd[i]) begin
        expHit = 1'b1; expIdx = i;
      end
    end
    pol  = int'((mPol[expIdx] >> (3 * did)) & 12'h7);
    need = sec ? (prv ? 1 : 2) : (prv ? 3 + int'(wr) : 5 + int'(wr));
    expGrant = !mEnf || (expHit && pol >= need);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqDid = 2'(did);
    reqSecure = sec; reqPriv = prv; reqWrite = wr;
    @(posedge clk); #1;
    check(rspValid && rspGrant == expGrant && rspFault == !expGrant &&
          rspHit == expHit && int'(rspRegion) == expIdx, req,
          {addr[15:0], 3'b0, rspValid, rspGrant, rspFault, rspHit, 1'b0, rspRegion, 4'(did), 4'(kind)},
          {addr[15:0], 3'b0, 1'b1, expGrant, !expGrant, expHit, 1'b0, 2'(expIdx), 4'(did), 4'(kind)});
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] addrs [10];
    for (int i = 0; i < 4; i++) begin
      mStart[i] = '0; mEnd[i] = '0; mValid[i] = 1'b0; mPol[i] = '0;
    end
    mEnf = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    check(!rspValid && !rspGrant && !rspFault && !rspHit && rspRegion == 0, "R10",
          {28'b0, rspValid, rspGrant, rspFault, rspHit}, 32'h0);
    // R10 no region enabled, R7 enforcement off: granted, no hit
    access(32'h150, 0, 0, "R10 R7");

    cfgWrite(2'd0, 2'd0, 32'h100); cfgWrite(2'd1, 2'd0, 32'h1FF);
    cfgWrite(2'd2, 2'd0, attrWord(1, 0, 3, 5, 7));
    cfgWrite(2'd0, 2'd1, 32'h180); cfgWrite(2'd1, 2'd1, 32'h2FF);
    cfgWrite(2'd2, 2'd1, attrWord(1, 7, 1, 0, 6));
    cfgWrite(2'd0, 2'd2, 32'h400); cfgWrite(2'd1, 2'd2, 32'h400);
    cfgWrite(2'd2, 2'd2, attrWord(1, 2, 4, 6, 0));
    cfgWrite(2'd0, 2'd3, 32'h0); cfgWrite(2'd1, 2'd3, 32'hFFFF_FFFF);
    cfgWrite(2'd2, 2'd3, attrWord(0, 7, 7, 7, 7));

    // R7 policy 0 region, enforcement off
    access(32'h120, 0, 0, "R7");
    access(32'h999, 1, 7, "R7");

    // R1 global enable, index field ignored
    cfgWrite(2'd3, 2'd2, 32'h1);

    addrs = '{32'hFF, 32'h100, 32'h17F, 32'h180, 32'h1FF, 32'h200,
              32'h2FF, 32'h300, 32'h400, 32'h401};
    // R2 R3 R8 R6 bounds, overlap priority, misses
    foreach (addrs[a])
      for (int d = 0; d < 4; d++)
        for (int k = 0; k < 8; k++)
          access(addrs[a], d, k, "R2 R3 R8 R6");

    // R5 R4 exhaustive policy sweep on region 0
    for (int p = 0; p < 8; p++) begin
      cfgWrite(2'd2, 2'd0, attrWord(1, p, p + 1, p + 2, p + 3));
      for (int d = 0; d < 4; d++)
        for (int k = 0; k < 8; k++)
          access(32'h150, d, k, "R5 R4");
    end

    // R2 enable the catch-all region: former misses now hit index 3
    cfgWrite(2'd2, 2'd3, attrWord(1, 4, 4, 4, 4));
    access(32'hFF, 0, 2, "R2 R3");
    access(32'h300, 2, 3, "R2 R3");
    access(32'hFFFF_FFFF, 3, 1, "R2 R3");
    // R2 disabling a region removes its match
    cfgWrite(2'd2, 2'd2, attrWord(0, 7, 7, 7, 7));
    access(32'h400, 1, 0, "R2");

    // R9 response lasts one cycle only
    access(32'h150, 0, 7, "R9");
    @(posedge clk); #1;
    check(!rspValid && !rspGrant && !rspFault && !rspHit, "R9",
          {28'b0, rspValid, rspGrant, rspFault, rspHit}, 32'h0);

    // R7 enforcement cleared again: deny policy and miss both granted
    cfgWrite(2'd2, 2'd0, attrWord(1, 0, 0, 0, 0));
    cfgWrite(2'd3, 2'd0, 32'h0);
    access(32'h150, 0, 7, "R7");
    cfgWrite(2'd2, 2'd3, attrWord(0, 0, 0, 0, 0));
    access(32'h300, 1, 0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule